// File: doc/BRIEF.md
# Write-Back Three-State Snooping Cache Controller

This block is the coherence controller of one direct-mapped, write-back cache on a shared atomic bus. Each line is in one of three states: invalid, shared (clean and read-only) or exclusive (the only copy, dirty and writable). The processor side takes reads and writes and holds off its ready signal until the access completes. Hits that need no bus traffic finish at once. Misses request the bus and, once granted, run one or two bus transactions before they complete.

The same block snoops the read and write misses that other caches place on the bus. A separate copy of the tags is used for the snoop lookup. When this cache holds the only dirty copy, it drives the block onto the snoop data lines and raises an abort in the same cycle, so memory takes that data and does not answer itself. A snoop that hits holds the processor port off for that cycle. Memory, the arbiter and the other caches sit outside the block.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid. `cpu_ready`, `bus_req` and `snp_abort` are low, and a snoop of any address does not abort.
- R2: A processor read to a line that is not present places a read miss (`bus_cmd`=1) at `bus_addr`=`cpu_addr`. It returns `bus_rdata` in the cycle of `bus_ack` and leaves the line shared.
- R3: A processor write to a line that is not present, or to a shared line, places a write miss (`bus_cmd`=2). It completes at `bus_ack` and leaves the line exclusive with the written data.
- R4: A read hit in shared or exclusive, and a write hit in exclusive, raise `cpu_ready` in the same cycle as `cpu_req`, with no bus request. `cpu_ready` is only ever high while `cpu_req` is high.
- R5: A miss whose index holds an exclusive line of another address first issues a write-back (`bus_cmd`=3) carrying the old address and data. After that write-back's `bus_ack`, the miss follows in the very next cycle.
- R6: A miss that replaces a shared line issues no write-back.
- R7: A snooped write miss (`snp_cmd`=2) that hits a shared line makes it invalid, so the next processor access to that address misses.
- R8: A snooped read miss (`snp_cmd`=1) that hits an exclusive line raises `snp_abort` in that cycle, drives the line's data on `snp_data`, and leaves the line shared.
- R9: A snooped write miss that hits an exclusive line raises `snp_abort` in that cycle, drives the line's data on `snp_data`, and leaves the line invalid.
- R10: In a cycle where a snoop hits a valid line, `cpu_ready` stays low. The processor access completes in a later cycle.
- R11: A snoop that misses, or a snooped read miss on a shared line, does not abort and leaves the line's state unchanged.
- R12: `bus_req` stays high from the first arbitration cycle until the `bus_ack` of the miss. A command is driven only while `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address (low IDX_W bits index the line) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus tenure request |
| bus_gnt | input | 1 | Bus tenure granted |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Current transaction completes |
| bus_rdata | input | DATA_W | Fill data for a miss |
| snp_valid | input | 1 | Another cache's miss is on the bus |
| snp_cmd | input | 2 | 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | Cancel memory's response; this cache supplies the block |
| snp_data | output | DATA_W | Block supplied on an owner snoop |

## Verification
Every cycle, the assertions check the following bus and port rules:
- an abort appears only with a snoop, and the processor is stalled while it is up;
- commands appear only under grant;
- the tenure is held until the miss is acknowledged;
- a write-back is followed at once by its miss.

The state changes (shared to invalid, exclusive to shared, fill to exclusive) are shown only by the bench's scenarios. The bench runs a reference model of the line states and of the latest value at every address through a long mixed sweep of reads, writes and snoops on conflicting addresses. It compares each command, each write-back payload and each returned value.

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] L_INV = 2'd0, L_SHR = 2'd1, L_EXC = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RDM = 2'd1, C_WRM = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] F_IDLE = 2'd0, F_ARB = 2'd1, F_WB = 2'd2, F_MISS = 2'd3;

  logic [1:0]        lst  [LINES];
  logic [TAG_W-1:0]  ctag [LINES];
  logic [TAG_W-1:0]  stag [LINES];
  logic [DATA_W-1:0] ldat [LINES];
  logic [1:0]        fsm;

  logic [IDX_W-1:0] cidx, sidx;
  logic [TAG_W-1:0] ctg, stg;
  logic             cpu_hit, snp_hit;

  assign cidx = cpu_addr[IDX_W-1:0];
  assign ctg  = cpu_addr[ADDR_W-1:IDX_W];
  assign sidx = snp_addr[IDX_W-1:0];
  assign stg  = snp_addr[ADDR_W-1:IDX_W];

  assign cpu_hit = (lst[cidx] != L_INV) && (ctag[cidx] == ctg) &&
                   (!cpu_we || lst[cidx] == L_EXC);
  assign snp_hit = snp_valid && (snp_cmd == C_RDM || snp_cmd == C_WRM) &&
                   (lst[sidx] != L_INV) && (stag[sidx] == stg);

  assign snp_abort = snp_hit && (lst[sidx] == L_EXC);
  assign snp_data  = ldat[sidx];

  assign cpu_ready = (fsm == F_IDLE && cpu_req && cpu_hit && !snp_hit) ||
                     (fsm == F_MISS && bus_ack);
  assign cpu_rdata = (fsm == F_MISS) ? bus_rdata : ldat[cidx];

  assign bus_req   = (fsm != F_IDLE);
  assign bus_cmd   = (fsm == F_WB)   ? C_WB :
                     (fsm == F_MISS) ? (cpu_we ? C_WRM : C_RDM) : C_NONE;
  assign bus_addr  = (fsm == F_WB) ? {ctag[cidx], cidx} : cpu_addr;
  assign bus_wdata = ldat[cidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      for (int i = 0; i < LINES; i++) begin
        lst[i]  <= L_INV;
        ctag[i] <= '0;
        stag[i] <= '0;
        ldat[i] <= '0;
      end
    end else begin
      case (fsm)
        F_IDLE:
          if (cpu_req && !snp_hit) begin
            if (cpu_hit) begin
              if (cpu_we) ldat[cidx] <= cpu_wdata;
            end else begin
              fsm <= F_ARB;
            end
          end
        F_ARB:
          if (bus_gnt) fsm <= (lst[cidx] == L_EXC) ? F_WB : F_MISS;
        F_WB:
          if (bus_ack) begin
            lst[cidx] <= L_INV;
            fsm       <= F_MISS;
          end
        default:
          if (bus_ack) begin
            ctag[cidx] <= ctg;
            stag[cidx] <= ctg;
            ldat[cidx] <= cpu_we ? cpu_wdata : bus_rdata;
            lst[cidx]  <= cpu_we ? L_EXC : L_SHR;
            fsm        <= F_IDLE;
          end
      endcase
      if (snp_hit) begin
        if (snp_cmd == C_WRM) lst[sidx] <= L_INV;
        else if (lst[sidx] == L_EXC) lst[sidx] <= L_SHR;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       bus_ack,
  input logic       snp_valid,
  input logic       snp_abort
);
  p_abort_needs_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> snp_valid);

  p_stall_on_owner_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> !cpu_ready);

  p_ready_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  p_cmd_under_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

  p_tenure_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_ack && (bus_cmd == 2'd1 || bus_cmd == 2'd2))) |=> bus_req);

  p_miss_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3 && bus_ack) |=> (bus_cmd == 2'd1 || bus_cmd == 2'd2));
endmodule

bind msi_snoop_cache msi_snoop_cache_chk i_chk (.*);

// File: tb/test_msi_snoop_cache.sv
module test_msi_snoop_cache;
  logic       clk = 0, rst_n = 0;
  logic       cpu_req = 0, cpu_we = 0, cpu_ready;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic       bus_req, bus_gnt = 0, bus_ack = 0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic       snp_valid = 0, snp_abort;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0, snp_data;

  msi_snoop_cache i_msi_snoop_cache (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int gst [4];
  int gtg [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cpu(input bit we, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int nwb, output int mcmd,
                        output int cyc, output bit dropped);
    bit done = 0, seen = 0;
    nwb = 0; mcmd = 0; cyc = 0; rd = 0; dropped = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    while (!done) begin
      #1;
      if (seen && !bus_req) dropped = 1;
      if (cpu_ready) begin
        rd = cpu_rdata; done = 1;
      end else begin
        if (bus_req) begin bus_gnt = 1; seen = 1; end
        if (bus_cmd != 0) begin
          if (bus_cmd == 3) begin
            nwb++;
            chk(bus_wdata == shadow[bus_addr], "R5", bus_wdata, shadow[bus_addr]);
            mem[bus_addr] = bus_wdata;
          end else begin
            mcmd = bus_cmd;
            chk(bus_addr == a, "R2", bus_addr, a);
            bus_rdata = mem[bus_addr];
          end
          bus_ack = 1;
          #1;
          if (cpu_ready) begin rd = cpu_rdata; done = 1; end
        end
      end
      @(negedge clk);
      bus_ack = 0;
      cyc++;
    end
    cpu_req = 0; bus_gnt = 0;
  endtask

  task automatic model_cpu(input bit we, input logic [7:0] a, input logic [7:0] d,
                           input string tag);
    int idx = a[1:0];
    int tg = a[7:2];
    bit hit = gst[idx] != 0 && gtg[idx] == tg && (!we || gst[idx] == 2);
    int ewb = (!hit && gst[idx] == 2) ? 1 : 0;
    int emc = hit ? 0 : (we ? 2 : 1);
    string t;
    logic [7:0] rd;
    int nwb, mcmd, cyc;
    bit dropped;
    t = (tag != "") ? tag : (hit ? "R4" : (we ? "R3" : "R2"));
    do_cpu(we, a, d, rd, nwb, mcmd, cyc, dropped);
    chk(nwb == ewb, (ewb != 0) ? "R5" : "R6", nwb, ewb);
    chk(mcmd == emc, t, mcmd, emc);
    if (!we) chk(rd == shadow[a], t, rd, shadow[a]);
    if (hit) chk(cyc == 1, "R4", cyc, 1);
    else chk(!dropped, "R12", dropped, 0);
    if (we) shadow[a] = d;
    if (!hit) begin gst[idx] = we ? 2 : 1; gtg[idx] = tg; end
  endtask

  task automatic model_snp(input int cmd, input logic [7:0] a, input logic [7:0] nv);
    int idx = a[1:0];
    int tg = a[7:2];
    bit hit = gst[idx] != 0 && gtg[idx] == tg;
    bit eab = hit && gst[idx] == 2;
    logic ab;
    logic [7:0] sd;
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd[1:0]; snp_addr = a;
    #1; ab = snp_abort; sd = snp_data;
    @(negedge clk);
    snp_valid = 0;
    chk(ab == eab, eab ? ((cmd == 2) ? "R9" : "R8") : "R11", ab, eab);
    if (eab) begin
      chk(sd == shadow[a], (cmd == 2) ? "R9" : "R8", sd, shadow[a]);
      mem[a] = sd;
    end
    if (hit) begin
      if (cmd == 2) gst[idx] = 0;
      else if (gst[idx] == 2) gst[idx] = 1;
    end
    if (cmd == 2) begin shadow[a] = nv; mem[a] = nv; end
  endtask

  function automatic logic [7:0] pick(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h01;
      4: return 8'h05;
      default: return 8'h22;
    endcase
  endfunction

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 3 + 1);
      shadow[i] = 8'(i * 3 + 1);
    end
    for (int i = 0; i < 4; i++) begin gst[i] = 0; gtg[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(cpu_ready == 0, "R1", cpu_ready, 0);
    chk(bus_req == 0, "R1", bus_req, 0);
    chk(snp_abort == 0, "R1", snp_abort, 0);
    model_snp(1, 8'h00, 8'h00);
    model_cpu(0, 8'h00, 8'h00, "R1");

    model_cpu(0, 8'h10, 8'h00, "R2");
    model_snp(1, 8'h10, 8'h00);
    model_cpu(0, 8'h10, 8'h00, "R11");
    model_snp(2, 8'h10, 8'h5C);
    model_cpu(0, 8'h10, 8'h00, "R7");

    model_cpu(1, 8'h02, 8'hA5, "R3");
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h02;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h02;
    #1;
    chk(cpu_ready == 0, "R10", cpu_ready, 0);
    chk(snp_abort == 1, "R8", snp_abort, 1);
    chk(snp_data == 8'hA5, "R8", snp_data, 8'hA5);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk(cpu_ready == 1, "R10", cpu_ready, 1);
    chk(cpu_rdata == 8'hA5, "R10", cpu_rdata, 8'hA5);
    @(negedge clk);
    cpu_req = 0;
    gst[2] = 1; mem[2] = 8'hA5;
    model_cpu(1, 8'h02, 8'h3E, "R8");
    model_snp(2, 8'h02, 8'h71);
    model_cpu(0, 8'h02, 8'h00, "R9");

    model_cpu(1, 8'h03, 8'h44, "R3");
    model_cpu(0, 8'h07, 8'h00, "R5");
    model_cpu(0, 8'h0B, 8'h00, "R6");

    for (int i = 0; i < 240; i++) begin
      int op = (i * 5 + i / 7) % 6;
      logic [7:0] a = pick((i * 3 + i / 4) % 6);
      logic [7:0] d = 8'(i * 11 + 7);
      if (op < 2) model_cpu(0, a, 8'h00, "");
      else if (op < 4) model_cpu(1, a, d, "");
      else model_snp(op - 3, a, d);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule